// File: doc/BRIEF.md
# Sideband Downstream Receive Endpoint

This block terminates inbound sideband requests for a local processor. A request arrives on a valid/ready port. It is taken only while firmware has turned access on and no earlier request is still waiting. When taken, its fields are latched into a bank of 32-bit registers that firmware can read. These fields are the port IDs, opcode, byte enables, address, extended header, data and transaction kind. The block then raises a maskable interrupt.

Firmware reads the request and then writes the consume bit. This frees the endpoint. If the request was non-posted, the consume write also sends a completion back on a valid/ready completion port. A separate boot-prepare pulse sets its own sticky status and interrupts the processor whatever the access and mask settings are.

A three-state machine controls the flow:
- IDLE: the endpoint is empty.
- HELD: a request is latched and unconsumed.
- SEND: a completion is offered.

The transitions are:
- IDLE to HELD on an accepted request.
- HELD to SEND on consume of a non-posted request.
- HELD to IDLE on consume of any other kind.
- SEND to IDLE when the completion handshake completes.

Top module: `sb_rx_endpoint`

## Requirements
- R1: After reset: `in_ready`, `irq` and `cpl_valid` are 0, access is off, and every register reads 0.
- R2: `in_ready` is 1 only when the access bit (register 7, bit 0) is 1 and the state is IDLE. A request offered while access is 0 is not captured.
- R3: On acceptance the fields are latched and reported in two registers. Register 0 holds dst in [7:0], src in [15:8], opcode in [23:16] and byte enables in [27:24]. Register 4 holds the data. The kind appears in register 5 [1:0], encoded 01 posted, 10 non-posted, 11 completion.
- R4: The address-length flag is reported in register 2 bit 31. When it is 1 (48-bit), register 1 holds all 32 lower address bits and register 2 [15:0] holds the upper 16. When it is 0 (16-bit), register 1 [31:16] and register 2 [15:0] read 0.
- R5: The extended-header flag is reported in register 3 bit 31. When it is 1, register 3 holds the SAI in [15:0] and the root space in [19:16]. When it is 0, both read 0.
- R6: The received flag (register 5 bit 31) is 1 from the cycle after capture until consume. While it is 1, `in_ready` is 0 and a further request leaves the latched fields unchanged.
- R7: Writing 1 to register 6 bit 31 (consume) in HELD clears the received flag. That bit always reads 0.
- R8: Consume of a non-posted request raises `cpl_valid` in the next cycle. The completion carries the captured source ID as `cpl_dst`, parameter `OWN_PORT` as `cpl_src`, and as `cpl_status` bits [2:0] of the consume write (000 success, 001 unsupported).
- R9: While `cpl_valid` is 1 and `cpl_ready` is 0, the completion fields are stable. After the handshake, `cpl_valid` is 0 and `in_ready` returns to 1.
- R10: Consume of a posted or completion-kind request produces no completion and returns the endpoint to IDLE.
- R11: `irq` equals received AND NOT mask, OR boot status. The mask is register 5 bit 30, read/write. The mask never changes the received flag.
- R12: A `boot_pulse` sets register 8 bit 0 and drives `irq` high regardless of access and mask. Writing 1 to that bit clears it.
- R13: A consume write while IDLE has no effect: no completion is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Inbound request valid |
| in_ready | output | 1 | Inbound request accepted this cycle |
| in_kind | input | 2 | Transaction kind (01 posted, 10 non-posted, 11 completion) |
| in_dst | input | 8 | Destination port ID |
| in_src | input | 8 | Source port ID |
| in_opc | input | 8 | Opcode |
| in_be | input | 4 | Byte enables |
| in_addr_lo | input | 32 | Lower address bits |
| in_addr_hi | input | 16 | Upper address bits |
| in_alen | input | 1 | Address length, 1 = 48-bit |
| in_ehp | input | 1 | Extended header present |
| in_sai | input | 16 | Security attribute |
| in_rs | input | 4 | Root space |
| in_data | input | 32 | Request data |
| boot_pulse | input | 1 | Boot-prepare message seen |
| cpl_valid | output | 1 | Completion valid |
| cpl_ready | input | 1 | Completion accepted |
| cpl_dst | output | 8 | Completion destination ID |
| cpl_src | output | 8 | Completion source ID |
| cpl_status | output | 3 | Completion status |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Interrupt to processor |

## Verification
The assertions assume a well-behaved completion receiver and a well-behaved firmware. They assume `cpl_ready` is sampled only as a handshake. They also assume that while the latch is held, only consume writes and mask writes move the machine. Stability is checked only across cycles in which `cpl_valid` is high and `cpl_ready` low. The stimulus draws random fields, kinds, masks, completion status and back-pressure lengths. It always offers requests on whole cycles and presents register writes as one-cycle strobes. Directed cases add:
- both address lengths;
- offering a request with access off;
- a second request while one is held;
- a consume with nothing held;
- the boot pulse under mask.

// File: rtl/sbrx_pkg.sv
package sbrx_pkg;
    localparam int PID_W = 8;
    localparam int OPC_W = 8;
    localparam int BE_W  = 4;
    localparam int DW    = 32;
    localparam int UA_W  = 16;
    localparam int SAI_W = 16;
    localparam int RS_W  = 4;
    localparam int CST_W = 3;
    localparam int RA_W  = 4;

    localparam logic [RA_W-1:0] RG_ATTR   = 4'd0;
    localparam logic [RA_W-1:0] RG_ALO    = 4'd1;
    localparam logic [RA_W-1:0] RG_AHI    = 4'd2;
    localparam logic [RA_W-1:0] RG_EXT    = 4'd3;
    localparam logic [RA_W-1:0] RG_DATA   = 4'd4;
    localparam logic [RA_W-1:0] RG_CTRL   = 4'd5;
    localparam logic [RA_W-1:0] RG_RESP   = 4'd6;
    localparam logic [RA_W-1:0] RG_ACCESS = 4'd7;
    localparam logic [RA_W-1:0] RG_BOOT   = 4'd8;

    typedef enum logic [1:0] {
        K_NONE      = 2'b00,
        K_POSTED    = 2'b01,
        K_NONPOSTED = 2'b10,
        K_CPL       = 2'b11
    } kind_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HELD = 2'd1,
        ST_SEND = 2'd2
    } ep_state_e;

    typedef struct packed {
        logic [PID_W-1:0] dst;
        logic [PID_W-1:0] src;
        logic [OPC_W-1:0] opc;
        logic [BE_W-1:0]  be;
        logic [DW-1:0]    addr_lo;
        logic [UA_W-1:0]  addr_hi;
        logic             alen;
        logic             ehp;
        logic [SAI_W-1:0] sai;
        logic [RS_W-1:0]  rs;
        logic [DW-1:0]    data;
        logic [1:0]       kind;
    } msg_t;
endpackage

// File: rtl/sbrx_capture.sv
module sbrx_capture
    import sbrx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  msg_t msg_in,
    output msg_t msg_q
);
    localparam int HALF = DW / 2;

    msg_t clean;

    // Fields that the flags mark invalid are stored as zero.
    always_comb begin
        clean = msg_in;
        if (!msg_in.alen) begin
            clean.addr_lo[DW-1:HALF] = '0;
            clean.addr_hi            = '0;
        end
        if (!msg_in.ehp) begin
            clean.sai = '0;
            clean.rs  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            msg_q <= '0;
        end else if (load) begin
            msg_q <= clean;
        end
    end

    // R6
    held_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(msg_q));
endmodule

// File: rtl/sbrx_fsm.sv
module sbrx_fsm
    import sbrx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      take,
    input  logic      consume,
    input  logic      is_np,
    input  logic      cpl_ready,
    output ep_state_e state,
    output logic      idle,
    output logic      held,
    output logic      cpl_valid
);
    ep_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (take)      state_d = ST_HELD;
            ST_HELD: if (consume)   state_d = is_np ? ST_SEND : ST_IDLE;
            ST_SEND: if (cpl_ready) state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        idle      = 1'b0;
        held      = 1'b0;
        cpl_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: idle      = 1'b1;
            ST_HELD: held      = 1'b1;
            ST_SEND: cpl_valid = 1'b1;
            default: idle      = 1'b1;
        endcase
    end

    assign state = state_q;

    // R9
    cpl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_valid && !cpl_ready |=> cpl_valid);
    // R10
    cpl_np_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        held && consume && !is_np |=> !cpl_valid);
    // R13
    idle_consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle && !take |=> !cpl_valid);
endmodule

// File: rtl/sbrx_regs.sv
module sbrx_regs
    import sbrx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [RA_W-1:0]  addr,
    input  logic [DW-1:0]    wdata,
    input  msg_t             msg_q,
    input  logic             received,
    input  logic             boot_pulse,
    output logic [DW-1:0]    rdata,
    output logic             mask,
    output logic             access_en,
    output logic             consume,
    output logic [CST_W-1:0] consume_sts,
    output logic             boot_sts
);
    localparam int RSV_ATTR = DW - 2*PID_W - OPC_W - BE_W;
    localparam int RSV_AHI  = DW - UA_W - 1;
    localparam int RSV_EXT  = DW - SAI_W - RS_W - 1;

    logic [CST_W-1:0] resp_sts;
    logic             wr_ctrl, wr_resp, wr_acc, wr_boot;

    assign wr_ctrl = we && (addr == RG_CTRL);
    assign wr_resp = we && (addr == RG_RESP);
    assign wr_acc  = we && (addr == RG_ACCESS);
    assign wr_boot = we && (addr == RG_BOOT);

    assign consume     = wr_resp && wdata[DW-1];
    assign consume_sts = wdata[CST_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask      <= 1'b0;
            access_en <= 1'b0;
            resp_sts  <= '0;
            boot_sts  <= 1'b0;
        end else begin
            if (wr_ctrl) mask      <= wdata[DW-2];
            if (wr_acc)  access_en <= wdata[0];
            if (wr_resp) resp_sts  <= wdata[CST_W-1:0];
            if (boot_pulse)                 boot_sts <= 1'b1;
            else if (wr_boot && wdata[0])   boot_sts <= 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            RG_ATTR:   rdata = {{RSV_ATTR{1'b0}}, msg_q.be, msg_q.opc, msg_q.src, msg_q.dst};
            RG_ALO:    rdata = msg_q.addr_lo;
            RG_AHI:    rdata = {msg_q.alen, {RSV_AHI{1'b0}}, msg_q.addr_hi};
            RG_EXT:    rdata = {msg_q.ehp, {RSV_EXT{1'b0}}, msg_q.rs, msg_q.sai};
            RG_DATA:   rdata = msg_q.data;
            RG_CTRL:   rdata = {received, mask, {(DW-4){1'b0}}, msg_q.kind};
            RG_RESP:   rdata = {{(DW-CST_W){1'b0}}, resp_sts};
            RG_ACCESS: rdata = {{(DW-1){1'b0}}, access_en};
            RG_BOOT:   rdata = {{(DW-1){1'b0}}, boot_sts};
            default:   rdata = '0;
        endcase
    end

    // R12
    boot_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        boot_pulse |=> boot_sts);
endmodule

// File: rtl/sb_rx_endpoint.sv
module sb_rx_endpoint
    import sbrx_pkg::*;
#(
    parameter logic [7:0] OWN_PORT = 8'h5A
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [1:0]  in_kind,
    input  logic [7:0]  in_dst,
    input  logic [7:0]  in_src,
    input  logic [7:0]  in_opc,
    input  logic [3:0]  in_be,
    input  logic [31:0] in_addr_lo,
    input  logic [15:0] in_addr_hi,
    input  logic        in_alen,
    input  logic        in_ehp,
    input  logic [15:0] in_sai,
    input  logic [3:0]  in_rs,
    input  logic [31:0] in_data,
    input  logic        boot_pulse,
    output logic        cpl_valid,
    input  logic        cpl_ready,
    output logic [7:0]  cpl_dst,
    output logic [7:0]  cpl_src,
    output logic [2:0]  cpl_status,
    input  logic        reg_we,
    input  logic [3:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq
);
    msg_t             msg_in, msg_q;
    ep_state_e        state;
    logic             idle, held, take, consume, mask, access_en, boot_sts;
    logic [CST_W-1:0] consume_sts, cpl_sts_q;

    assign msg_in = '{dst: in_dst, src: in_src, opc: in_opc, be: in_be,
                      addr_lo: in_addr_lo, addr_hi: in_addr_hi, alen: in_alen,
                      ehp: in_ehp, sai: in_sai, rs: in_rs, data: in_data,
                      kind: in_kind};

    assign in_ready = idle && access_en;
    assign take     = in_valid && in_ready;

    sbrx_capture u_cap (
        .clk(clk), .rst_n(rst_n), .load(take), .msg_in(msg_in), .msg_q(msg_q)
    );

    sbrx_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .take(take), .consume(consume),
        .is_np(msg_q.kind == K_NONPOSTED), .cpl_ready(cpl_ready),
        .state(state), .idle(idle), .held(held), .cpl_valid(cpl_valid)
    );

    sbrx_regs u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .msg_q(msg_q), .received(held), .boot_pulse(boot_pulse), .rdata(reg_rdata),
        .mask(mask), .access_en(access_en), .consume(consume),
        .consume_sts(consume_sts), .boot_sts(boot_sts)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               cpl_sts_q <= '0;
        else if (held && consume) cpl_sts_q <= consume_sts;
    end

    assign cpl_dst    = msg_q.src;
    assign cpl_src    = OWN_PORT;
    assign cpl_status = cpl_sts_q;
    assign irq        = (held && !mask) || boot_sts;

    // R2
    ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> access_en && state == ST_IDLE);
    // R6
    no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        held |-> !in_ready);
    // R9
    cpl_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_valid && !cpl_ready |=> $stable(cpl_dst) && $stable(cpl_status));
    // R11
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        held && !mask |-> irq);
    // R8
    cpl_after_consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpl_valid) |-> $past(held) && $past(consume));
endmodule

// File: tb/tb_sb_rx_endpoint.sv
module tb_sb_rx_endpoint;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] OWN = 8'h5A;

    logic        clk = 0, rst_n = 0;
    logic        in_valid = 0, in_ready;
    logic [1:0]  in_kind = 0;
    logic [7:0]  in_dst = 0, in_src = 0, in_opc = 0;
    logic [3:0]  in_be = 0, in_rs = 0;
    logic [31:0] in_addr_lo = 0, in_data = 0;
    logic [15:0] in_addr_hi = 0, in_sai = 0;
    logic        in_alen = 0, in_ehp = 0, boot_pulse = 0;
    logic        cpl_valid, cpl_ready = 0;
    logic [7:0]  cpl_dst, cpl_src;
    logic [2:0]  cpl_status;
    logic        reg_we = 0;
    logic [3:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0, reg_rdata;
    logic        irq;

    int checks = 0, fails = 0, cycles = 0;
    bit done = 0;

    sb_rx_endpoint #(.OWN_PORT(OWN)) dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            fails++;
            $display("FAIL watchdog: act=%0d expected below 100000 cycles", cycles);
            summary();
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 0;
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] d);
        reg_addr = a; #1; d = reg_rdata;
    endtask

    function automatic logic [31:0] f_attr(logic [7:0] d, logic [7:0] s, logic [7:0] o, logic [3:0] b);
        return {4'b0, b, o, s, d};
    endfunction
    function automatic logic [31:0] f_alo(logic [31:0] lo, logic al);
        return al ? lo : {16'h0, lo[15:0]};
    endfunction
    function automatic logic [31:0] f_ahi(logic [15:0] hi, logic al);
        return al ? {1'b1, 15'h0, hi} : 32'h0;
    endfunction
    function automatic logic [31:0] f_ext(logic [15:0] sai, logic [3:0] rs, logic e);
        return e ? {1'b1, 11'h0, rs, sai} : 32'h0;
    endfunction
    function automatic logic [31:0] f_ctrl(logic [1:0] k, logic rcv, logic m);
        return {rcv, m, 28'h0, k};
    endfunction

    task automatic offer();
        @(negedge clk); in_valid = 1;
        @(negedge clk); in_valid = 0;
    endtask

    task automatic rand_fields(logic [1:0] k, logic al, logic e);
        in_kind = k; in_alen = al; in_ehp = e;
        in_dst = 8'($urandom); in_src = 8'($urandom); in_opc = 8'($urandom);
        in_be = 4'($urandom); in_addr_lo = $urandom; in_addr_hi = 16'($urandom);
        in_sai = 16'($urandom); in_rs = 4'($urandom); in_data = $urandom;
    endtask

    initial begin
        logic [31:0] r;
        void'($urandom(32'h1234_5678));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 in_ready", in_ready, 0);
        chk("R1 irq", irq, 0);
        chk("R1 cpl_valid", cpl_valid, 0);
        for (int a = 0; a < 9; a++) begin
            rd(4'(a), r); chk("R1 reg", r, 0);
        end
        // R2 access off: not captured
        rand_fields(2'b10, 1, 1);
        offer();
        rd(4'd5, r); chk("R2 no capture with access off", r, 0);
        rd(4'd0, r); chk("R2 attr untouched", r, 0);
        wr(4'd7, 1);
        chk("R2 ready with access on", in_ready, 1);
        // R13 consume while idle
        wr(4'd6, 32'h8000_0001);
        chk("R13 no completion", cpl_valid, 0);
        chk("R13 still ready", in_ready, 1);
        // R12 boot pulse with mask set and access off
        wr(4'd5, 32'h4000_0000);
        wr(4'd7, 0);
        @(negedge clk); boot_pulse = 1; @(negedge clk); boot_pulse = 0;
        chk("R12 irq on boot", irq, 1);
        rd(4'd8, r); chk("R12 boot status", r, 1);
        wr(4'd8, 1);
        rd(4'd8, r); chk("R12 boot cleared", r, 0);
        chk("R12 irq dropped", irq, 0);
        wr(4'd5, 0);
        wr(4'd7, 1);

        for (int it = 0; it < 40; it++) begin
            logic [1:0] k;
            logic al, e, m;
            logic [2:0] st;
            logic [7:0] sdst, ssrc, sopc;
            logic [3:0] sbe;
            int hold;
            k  = 2'(1 + ($urandom % 3));
            al = (it == 0) ? 1 : (it == 1) ? 0 : 1'($urandom);
            e  = (it == 2) ? 0 : (it == 3) ? 1 : 1'($urandom);
            if (it == 4) k = 2'b10;
            if (it == 5) k = 2'b01;
            rand_fields(k, al, e);
            sdst = in_dst; ssrc = in_src; sopc = in_opc; sbe = in_be;
            offer();
            rd(4'd0, r); chk("R3 attr", r, f_attr(sdst, ssrc, sopc, sbe));
            rd(4'd4, r); chk("R3 data", r, in_data);
            rd(4'd1, r); chk("R4 addr lo", r, f_alo(in_addr_lo, al));
            rd(4'd2, r); chk("R4 addr hi", r, f_ahi(in_addr_hi, al));
            rd(4'd3, r); chk("R5 ext hdr", r, f_ext(in_sai, in_rs, e));
            rd(4'd5, r); chk("R6 received kind", r, f_ctrl(k, 1, 0));
            chk("R6 ready low", in_ready, 0);
            // second request must not overwrite
            rand_fields(2'b01, 1, 1);
            offer();
            rd(4'd0, r); chk("R6 no overwrite", r, f_attr(sdst, ssrc, sopc, sbe));
            // R11 mask
            m = 1'($urandom);
            wr(4'd5, {1'b0, m, 30'h0});
            chk("R11 irq vs mask", irq, !m);
            rd(4'd5, r); chk("R11 mask keeps status", r, f_ctrl(k, 1, m));
            wr(4'd5, 0);
            // R7 consume
            st = 3'($urandom % 2);
            wr(4'd6, {1'b1, 28'h0, st});
            rd(4'd5, r); chk("R7 received cleared", r[31], 0);
            rd(4'd6, r); chk("R7 consume reads 0", r[31], 0);
            if (k == 2'b10) begin
                chk("R8 cpl_valid", cpl_valid, 1);
                chk("R8 cpl_dst", cpl_dst, ssrc);
                chk("R8 cpl_src", cpl_src, OWN);
                chk("R8 cpl_status", cpl_status, st);
                hold = $urandom % 4;
                for (int h = 0; h < hold; h++) begin
                    if (h == 0) wr(4'd6, 32'h0000_0007);
                    else @(negedge clk);
                    chk("R9 valid held", cpl_valid, 1);
                    chk("R9 dst stable", cpl_dst, ssrc);
                    chk("R9 status stable", cpl_status, st);
                end
                cpl_ready = 1; @(negedge clk); cpl_ready = 0;
                chk("R9 valid dropped", cpl_valid, 0);
                chk("R9 ready back", in_ready, 1);
            end else begin
                chk("R10 no completion", cpl_valid, 0);
                chk("R10 ready back", in_ready, 1);
            end
        end
        done = 1;
        summary();
    end
endmodule